// File: doc/BRIEF.md
# Indexed and Vectored Address Generator

This unit turns a request into a 16-bit memory address in one of two ways. In indexed mode it picks one of two independent 16-bit base registers and adds a signed 8-bit displacement to it. The displacement is sign-extended first, and the sum wraps around inside the 16-bit address space. In vectored mode it places an 8-bit page register in the upper byte of the address and the vector byte supplied by an interrupting device in the lower byte.

The base registers and the page register are loaded through their own write strobes. Software-visible decode, the memory access itself and the interrupt handshake all sit outside the block. Each request returns one registered address, flagged by a single-cycle valid pulse.

Top module: `idx_vec_agen`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and valid_o is 0. Reset also clears both base registers and the page register to 0, so the first indexed request with displacement 0 and the first vectored request with vector 0 both return address 0.
- R2: valid_o is 1 in the cycle after every clock edge at which req_i is 1, and 0 after every edge at which req_i is 0. Back-to-back requests keep it high.
- R3: In indexed mode (mode_i = 0), addr_o equals the selected base plus the displacement interpreted as two's complement, modulo 65536. No carry or borrow is reported.
- R4: idx_sel_i = 0 selects base 0 and idx_sel_i = 1 selects base 1.
- R5: A displacement with bit 7 set is negative (0x80 = -128, 0xFF = -1) and lowers the address.
- R6: In vectored mode (mode_i = 1), addr_o[15:8] is the page register and addr_o[7:0] is vec_i. disp_i and idx_sel_i have no effect on the result.
- R7: When a register write and a request fall on the same edge, the request uses the value the register held before that write. The new value is used from the next request on.
- R8: addr_o keeps its last value on every edge without a request.
- R9: Base i is written only when idx_we_i[i] is 1. A write to one base leaves the other base unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_we_i | input | 2 | Write strobe for each base register |
| idx_wdata_i | input | 16 | Write data for the base registers |
| page_we_i | input | 1 | Write strobe for the page register |
| page_wdata_i | input | 8 | Write data for the page register |
| req_i | input | 1 | Address request |
| mode_i | input | 1 | 0 = indexed, 1 = vectored |
| idx_sel_i | input | 1 | Selects the base register in indexed mode |
| disp_i | input | 8 | Signed displacement |
| vec_i | input | 8 | Vector byte from the interrupting device |
| addr_o | output | 16 | Registered address |
| valid_o | output | 1 | One-cycle pulse marking a fresh address |

## Verification
The assertions assume that idx_sel_i names an existing base register and that every input is steady around the rising edge. They also assume the run starts with rst_ni held low. The bench changes inputs only on the falling edge and drives idx_sel_i with 0 or 1 only. It asserts reset before any stimulus and compares both outputs against its own model after every rising edge. The stimulus includes requests that coincide with writes, displacements that wrap past either end of the address space, and vectored requests that carry arbitrary displacement and select values.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic {
    MODE_INDEXED = 1'b0,
    MODE_VECTOR  = 1'b1
  } agen_mode_e;
endpackage

// File: rtl/agen_idx_regs.sv
module agen_idx_regs #(
  parameter int NUM_IDX = 2,
  parameter int ADDR_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_IDX-1:0]             we_i,
  input  logic [ADDR_W-1:0]              wdata_i,
  output logic [NUM_IDX-1:0][ADDR_W-1:0] base_o
);
  for (genvar g = 0; g < NUM_IDX; g++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      base_o[g] <= '0;
      else if (we_i[g]) base_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/agen_page_reg.sv
module agen_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_o <= '0;
    else if (we_i) page_o <= wdata_i;
  end
endmodule

// File: rtl/agen_disp_add.sv
module agen_disp_add #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int EXT_W = ADDR_W - DISP_W;
  logic [ADDR_W-1:0] disp_ext;

  // sign-extend, then add; carry out is dropped
  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign sum_o    = base_i + disp_ext;
endmodule

// File: rtl/idx_vec_agen.sv
module idx_vec_agen #(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 8,
  parameter int VEC_W   = 8,
  parameter int NUM_IDX = 2,
  localparam int PAGE_W    = ADDR_W - VEC_W,
  localparam int IDX_SEL_W = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IDX-1:0]   idx_we_i,
  input  logic [ADDR_W-1:0]    idx_wdata_i,
  input  logic                 page_we_i,
  input  logic [PAGE_W-1:0]    page_wdata_i,
  input  logic                 req_i,
  input  logic                 mode_i,
  input  logic [IDX_SEL_W-1:0] idx_sel_i,
  input  logic [DISP_W-1:0]    disp_i,
  input  logic [VEC_W-1:0]     vec_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 valid_o
);
  import agen_pkg::*;

  logic [NUM_IDX-1:0][ADDR_W-1:0] base_q;
  logic [PAGE_W-1:0]              page_q;
  logic [ADDR_W-1:0]              base_sel;
  logic [ADDR_W-1:0]              idx_addr;
  logic [ADDR_W-1:0]              vec_addr;
  logic [ADDR_W-1:0]              addr_d;
  agen_mode_e                     mode;

  agen_idx_regs #(.NUM_IDX(NUM_IDX), .ADDR_W(ADDR_W)) u_idx_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (idx_we_i),
    .wdata_i (idx_wdata_i),
    .base_o  (base_q)
  );

  agen_page_reg #(.PAGE_W(PAGE_W)) u_page_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (page_we_i),
    .wdata_i (page_wdata_i),
    .page_o  (page_q)
  );

  assign base_sel = base_q[idx_sel_i];

  agen_disp_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_disp_add (
    .base_i (base_sel),
    .disp_i (disp_i),
    .sum_o  (idx_addr)
  );

  assign vec_addr = {page_q, vec_i};
  assign mode     = agen_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_VECTOR: addr_d = vec_addr;
      default:     addr_d = idx_addr;
    endcase
  end

  // registers update on the same edge, so a coincident request sees old values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
  parameter int ADDR_W    = 16,
  parameter int DISP_W    = 8,
  parameter int VEC_W     = 8,
  parameter int NUM_IDX   = 2,
  parameter int PAGE_W    = 8,
  parameter int IDX_SEL_W = 1
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_i,
  input logic                           mode_i,
  input logic [IDX_SEL_W-1:0]           idx_sel_i,
  input logic [DISP_W-1:0]              disp_i,
  input logic [VEC_W-1:0]               vec_i,
  input logic [ADDR_W-1:0]              addr_o,
  input logic                           valid_o,
  input logic [NUM_IDX-1:0][ADDR_W-1:0] base_q,
  input logic [PAGE_W-1:0]              page_q
);
  localparam int EXT_W = ADDR_W - DISP_W;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_out_r1: assert (addr_o == '0 && !valid_o);
    end
  end

  p_valid_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);

  p_no_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(addr_o));

  p_vec_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i) |=> addr_o[VEC_W-1:0] == $past(vec_i));

  p_vec_page_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i) |=> addr_o[ADDR_W-1:VEC_W] == $past(page_q));

  // R3, R7: subtracting the displacement back out recovers the pre-edge base
  p_idx_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !mode_i) |=>
      ADDR_W'(addr_o - {{EXT_W{$past(disp_i[DISP_W-1])}}, $past(disp_i)})
        == $past(base_q[idx_sel_i]));
endmodule

bind idx_vec_agen agen_chk #(
  .ADDR_W(ADDR_W), .DISP_W(DISP_W), .VEC_W(VEC_W), .NUM_IDX(NUM_IDX),
  .PAGE_W(PAGE_W), .IDX_SEL_W(IDX_SEL_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .mode_i    (mode_i),
  .idx_sel_i (idx_sel_i),
  .disp_i    (disp_i),
  .vec_i     (vec_i),
  .addr_o    (addr_o),
  .valid_o   (valid_o),
  .base_q    (base_q),
  .page_q    (page_q)
);

// File: tb/idx_vec_agen_tb.sv
module idx_vec_agen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  idx_we_i = '0;
  logic [15:0] idx_wdata_i = '0;
  logic        page_we_i = 1'b0;
  logic [7:0]  page_wdata_i = '0;
  logic        req_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [0:0]  idx_sel_i = '0;
  logic [7:0]  disp_i = '0;
  logic [7:0]  vec_i = '0;
  logic [15:0] addr_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;

  int m_base [2];
  int m_page;
  int m_addr;
  int m_valid;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  idx_vec_agen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_we_i(idx_we_i), .idx_wdata_i(idx_wdata_i),
    .page_we_i(page_we_i), .page_wdata_i(page_wdata_i), .req_i(req_i), .mode_i(mode_i),
    .idx_sel_i(idx_sel_i), .disp_i(disp_i), .vec_i(vec_i), .addr_o(addr_o), .valid_o(valid_o)
  );

  task automatic check(input string tag);
    checks++;
    if (int'(addr_o) != m_addr || int'(valid_o) != m_valid) begin
      errors++;
      $display("FAIL %s: addr=%h valid=%0d expected addr=%h valid=%0d",
               tag, addr_o, valid_o, m_addr[15:0], m_valid);
    end
  endtask

  // drive at the falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input bit req, input bit mode, input int sel, input int disp,
                      input int vec, input bit [1:0] we, input int wd, input bit pwe,
                      input int pwd, input string tag);
    int d;
    int v;
    req_i = req; mode_i = mode; idx_sel_i = 1'(sel); disp_i = 8'(disp); vec_i = 8'(vec);
    idx_we_i = we; idx_wdata_i = 16'(wd); page_we_i = pwe; page_wdata_i = 8'(pwd);
    m_valid = req ? 1 : 0;
    if (req) begin
      if (mode) m_addr = m_page * 256 + vec;
      else begin
        d = (disp >= 128) ? disp - 256 : disp;
        v = m_base[sel] + d;
        if (v < 0) v += 65536;
        m_addr = v % 65536;
      end
    end
    for (int i = 0; i < 2; i++) if (we[i]) m_base[i] = wd;
    if (pwe) m_page = pwd;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 2'b00, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R2: watchdog expired, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_base[0] = 0; m_base[1] = 0; m_page = 0; m_addr = 0; m_valid = 0;
    repeat (3) @(negedge clk_i);
    check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");
    step(1, 0, 0, 0, 0, 2'b00, 0, 0, 0, "R1 base0 cleared");
    step(1, 0, 1, 0, 0, 2'b00, 0, 0, 0, "R1 base1 cleared");
    step(1, 1, 0, 0, 0, 2'b00, 0, 0, 0, "R1 page cleared");

    step(0, 0, 0, 0, 0, 2'b01, 'h1234, 0, 0, "R9 write base0");
    step(0, 0, 0, 0, 0, 2'b10, 'hABCD, 0, 0, "R9 write base1");
    step(0, 0, 0, 0, 0, 2'b00, 0, 1, 'h5A, "R8 write page");
    step(1, 0, 0, 'h10, 0, 2'b00, 0, 0, 0, "R3 base0 plus 16");
    step(1, 0, 1, 'h05, 0, 2'b00, 0, 0, 0, "R4 base1 select");
    step(1, 0, 0, 'h05, 0, 2'b00, 0, 0, 0, "R4 base0 select");
    step(1, 0, 0, 'hF0, 0, 2'b00, 0, 0, 0, "R5 minus 16");
    step(1, 0, 0, 'h80, 0, 2'b00, 0, 0, 0, "R5 minus 128");
    step(1, 0, 1, 'hFF, 0, 2'b00, 0, 0, 0, "R5 minus 1");
    step(1, 0, 0, 'h7F, 0, 2'b00, 0, 0, 0, "R3 plus 127");

    step(0, 0, 0, 0, 0, 2'b10, 'hFFF0, 0, 0, "R8 write base1 top");
    step(1, 0, 1, 'h20, 0, 2'b00, 0, 0, 0, "R3 wrap upward");
    step(0, 0, 0, 0, 0, 2'b01, 'h0005, 0, 0, "R8 write base0 low");
    step(1, 0, 0, 'hF0, 0, 2'b00, 0, 0, 0, "R3 wrap downward");

    step(1, 1, 1, 'h7F, 'h3C, 2'b00, 0, 0, 0, "R6 vectored ignores disp/sel");
    step(1, 1, 0, 'h80, 'hC3, 2'b00, 0, 0, 0, "R6 vectored second vector");
    idle("R2 valid drops");
    idle("R8 address held");
    idle("R8 address held again");

    step(1, 0, 0, 'h01, 0, 2'b01, 'h2000, 0, 0, "R7 coincident base write uses old");
    step(1, 0, 0, 'h01, 0, 2'b00, 0, 0, 0, "R7 new base used next");
    step(1, 1, 0, 0, 'h11, 2'b00, 0, 1, 'hE7, "R7 coincident page write uses old");
    step(1, 1, 0, 0, 'h11, 2'b00, 0, 0, 0, "R7 new page used next");

    step(0, 0, 0, 0, 0, 2'b10, 'h4444, 0, 0, "R9 write base1 only");
    step(1, 0, 0, 0, 0, 2'b00, 0, 0, 0, "R9 base0 unchanged");
    step(1, 0, 1, 0, 0, 2'b00, 0, 0, 0, "R9 base1 updated");

    for (int n = 0; n < 60; n++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 1),
           $urandom_range(0, 255), $urandom_range(0, 255), 2'($urandom_range(0, 3)),
           $urandom_range(0, 65535), 1'($urandom_range(0, 1)), $urandom_range(0, 255),
           "R2 R3 mixed pattern");
    end
    idle("R2 final idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule